// File: doc/BRIEF.md
# Slot-Ring Queue Lock

This block arbitrates one exclusive resource among a fixed set of requesters by keeping a ring of flag registers, one per queue place. Each flag is either waiting or holding. A requester that asks for the lock is given the next place on the ring from a counter that wraps at the ring size. From then on it watches only the flag of its own place. When the current owner gives the lock up, its own flag goes back to waiting and the flag one step further round the ring becomes holding. The owner of that place is granted next, so ownership moves through the queue in arrival order.

Requests that arrive in the same cycle are queued in ascending requester index. The ring has a fixed number of places. A request that would need more places than the ring holds is dropped and sets an overflow flag. The number of requesters and the number of ring places are separate parameters, so a design may connect more requesters than it expects to have waiting at once. A generate option chooses whether the overflow flag is sticky until reset or reports only the cycle of the drop.

Top module: `aql_top`

## Requirements
- R1: After reset no grant is asserted, no requester is queued and `overflow_o` is low. Place 0 holds the lock, so the first accepted requester is given place 0.
- R2: An accepted request gives its requester the place held in the place counter and advances the counter by one, modulo SLOTS. Requests accepted in the same clock edge take consecutive places in ascending requester index. `slot_o[i*SLOT_W +: SLOT_W]` shows requester i's place from the edge that accepts it.
- R3: `grant_o[i]` is high exactly when requester i is queued and its place's flag is holding. At most one grant is high at a time.
- R4: A release pulse from the granted requester is taken at the clock edge. After that edge the releaser is no longer granted or queued, and the requester on place (p+1) mod SLOTS is granted if one is queued there.
- R5: Grants follow acceptance order (FIFO).
- R6: A release pulse from a requester that does not hold the grant has no effect on any output.
- R7: An acquire pulse from a requester that is already queued is ignored, and its place is unchanged. This includes the holder in the cycle it releases.
- R8: A request is accepted only while fewer than SLOTS requesters are queued, counting requests from lower indices in the same edge. A request beyond that is dropped and raises `overflow_o`. With OVF_STICKY=1, `overflow_o` stays high until reset.
- R9: Places freed by releases are handed out again when the counter wraps.
- R10: When the queue is empty, the lock waits on the next place the counter will give out. A requester accepted at an edge into the empty queue is granted directly after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_i | input | N_REQ | Per-requester acquire pulse |
| rel_i | input | N_REQ | Per-requester release pulse |
| grant_o | output | N_REQ | Per-requester lock grant |
| queued_o | output | N_REQ | Requester holds a place on the ring |
| slot_o | output | N_REQ*SLOT_W | Place assigned to each requester |
| overflow_o | output | 1 | A request found the ring full |

## Verification
The hardest case to reach is a full ring in which a same-cycle burst of acquires must be cut off partway. Lower-index requesters are still accepted, the rest are dropped, and the counter has already wrapped onto places freed earlier. The bench uses more requesters than places. It fills the ring with one simultaneous burst, pushes one more request into the full ring, and then drains and refills the ring so that places are reused. After that, a long run of random acquires, holder releases and stray releases from non-holders is compared every cycle against a queue-based reference model.

// File: rtl/aql_pkg.sv
package aql_pkg;

   typedef enum logic {
      MUST_WAIT = 1'b0,
      HAS_LOCK  = 1'b1
   } slot_flag_e;

   function automatic int ring_add(input int base, input int delta, input int modulus);
      return (base + delta) % modulus;
   endfunction

endpackage

// File: rtl/aql_slot_ring.sv
module aql_slot_ring #(
   parameter int SLOTS = 4,
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rel_fire,
   input  logic [SLOT_W-1:0] rel_slot,
   output logic [SLOTS-1:0]  holding_o
);
   import aql_pkg::*;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam int PREV = ring_add(s, SLOTS - 1, SLOTS);
      slot_flag_e flag_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q <= (s == 0) ? HAS_LOCK : MUST_WAIT;
         end else if (rel_fire) begin
            if (rel_slot == SLOT_W'(s)) begin
               flag_q <= MUST_WAIT;
            end else if (rel_slot == SLOT_W'(PREV)) begin
               flag_q <= HAS_LOCK;
            end
         end
      end

      assign holding_o[s] = (flag_q == HAS_LOCK);
   end

endmodule

// File: rtl/aql_alloc.sv
module aql_alloc #(
   parameter int N_REQ      = 4,
   parameter int SLOTS      = 4,
   parameter bit OVF_STICKY = 1'b1,
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int CNT_W  = $clog2(SLOTS + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_REQ-1:0]        want,
   input  logic                    rel_fire,
   output logic [N_REQ-1:0]        accept,
   output logic [N_REQ*SLOT_W-1:0] new_slot,
   output logic [CNT_W-1:0]        occ_o,
   output logic                    overflow_o
);
   import aql_pkg::*;

   logic [SLOT_W-1:0] next_q;
   logic [CNT_W-1:0]  occ_q;
   logic              ovf_q;
   logic              drop;
   int                taken;

   always_comb begin
      taken    = 0;
      drop     = 1'b0;
      accept   = '0;
      new_slot = '0;
      for (int i = 0; i < N_REQ; i++) begin
         if (want[i]) begin
            if ((int'(occ_q) + taken) < SLOTS) begin
               accept[i] = 1'b1;
               new_slot[i*SLOT_W +: SLOT_W] = SLOT_W'(ring_add(int'(next_q), taken, SLOTS));
               taken = taken + 1;
            end else begin
               drop = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         next_q <= '0;
         occ_q  <= '0;
      end else begin
         next_q <= SLOT_W'(ring_add(int'(next_q), taken, SLOTS));
         occ_q  <= CNT_W'(int'(occ_q) + taken - (rel_fire ? 1 : 0));
      end
   end

   if (OVF_STICKY) begin : g_ovf_sticky
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ovf_q <= 1'b0;
         else        ovf_q <= ovf_q | drop;
      end
   end else begin : g_ovf_pulse
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ovf_q <= 1'b0;
         else        ovf_q <= drop;
      end
   end

   assign occ_o      = occ_q;
   assign overflow_o = ovf_q;

endmodule

// File: rtl/aql_waiter.sv
module aql_waiter #(
   parameter int SLOTS = 4,
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [SLOT_W-1:0] new_slot,
   input  logic              rel_req,
   input  logic [SLOTS-1:0]  holding,
   output logic              queued_o,
   output logic              grant_o,
   output logic              rel_fire_o,
   output logic [SLOT_W-1:0] slot_o
);
   logic              queued_q;
   logic [SLOT_W-1:0] slot_q;

   assign grant_o    = queued_q & holding[slot_q];
   assign rel_fire_o = rel_req & grant_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         queued_q <= 1'b0;
         slot_q   <= '0;
      end else if (accept) begin
         queued_q <= 1'b1;
         slot_q   <= new_slot;
      end else if (rel_fire_o) begin
         queued_q <= 1'b0;
      end
   end

   assign queued_o = queued_q;
   assign slot_o   = slot_q;

endmodule

// File: rtl/aql_top.sv
module aql_top #(
   parameter int N_REQ      = 4,
   parameter int SLOTS      = 4,
   parameter bit OVF_STICKY = 1'b1,
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int CNT_W  = $clog2(SLOTS + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_REQ-1:0]        acq_i,
   input  logic [N_REQ-1:0]        rel_i,
   output logic [N_REQ-1:0]        grant_o,
   output logic [N_REQ-1:0]        queued_o,
   output logic [N_REQ*SLOT_W-1:0] slot_o,
   output logic                    overflow_o
);

   if (SLOTS < 2) begin : g_bad_slots
      $error("aql_top: SLOTS must be at least 2");
   end
   if (N_REQ < 1) begin : g_bad_req
      $error("aql_top: N_REQ must be at least 1");
   end

   logic [N_REQ-1:0]        want;
   logic [N_REQ-1:0]        accept;
   logic [N_REQ-1:0]        rel_fire_vec;
   logic [N_REQ*SLOT_W-1:0] new_slot;
   logic [SLOTS-1:0]        holding;
   logic [CNT_W-1:0]        occ;
   logic                    rel_fire;
   logic [SLOT_W-1:0]       rel_slot;

   assign want = acq_i & ~queued_o;

   aql_alloc #(
      .N_REQ     (N_REQ),
      .SLOTS     (SLOTS),
      .OVF_STICKY(OVF_STICKY)
   ) u_alloc (
      .clk       (clk),
      .rst_n     (rst_n),
      .want      (want),
      .rel_fire  (rel_fire),
      .accept    (accept),
      .new_slot  (new_slot),
      .occ_o     (occ),
      .overflow_o(overflow_o)
   );

   aql_slot_ring #(
      .SLOTS(SLOTS)
   ) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .rel_fire (rel_fire),
      .rel_slot (rel_slot),
      .holding_o(holding)
   );

   for (genvar i = 0; i < N_REQ; i++) begin : g_req
      aql_waiter #(
         .SLOTS(SLOTS)
      ) u_waiter (
         .clk       (clk),
         .rst_n     (rst_n),
         .accept    (accept[i]),
         .new_slot  (new_slot[i*SLOT_W +: SLOT_W]),
         .rel_req   (rel_i[i]),
         .holding   (holding),
         .queued_o  (queued_o[i]),
         .grant_o   (grant_o[i]),
         .rel_fire_o(rel_fire_vec[i]),
         .slot_o    (slot_o[i*SLOT_W +: SLOT_W])
      );
   end

   always_comb begin
      rel_slot = '0;
      for (int i = 0; i < N_REQ; i++) begin
         rel_slot = rel_slot | (slot_o[i*SLOT_W +: SLOT_W] & {SLOT_W{rel_fire_vec[i]}});
      end
   end

   assign rel_fire = |rel_fire_vec;

endmodule

// File: rtl/aql_checker.sv
module aql_checker #(
   parameter int N_REQ      = 4,
   parameter int SLOTS      = 4,
   parameter bit OVF_STICKY = 1'b1,
   localparam int CNT_W = $clog2(SLOTS + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_REQ-1:0] acq_i,
   input logic [N_REQ-1:0] rel_i,
   input logic [N_REQ-1:0] grant_o,
   input logic [N_REQ-1:0] queued_o,
   input logic             overflow_o,
   input logic [SLOTS-1:0] holding,
   input logic [CNT_W-1:0] occ
);

   AST_ONE_HOLDING_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(holding) == 1); // R3

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o)); // R3

   AST_GRANT_NEEDS_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o & ~queued_o) == '0); // R3

   AST_OCC_MATCHES_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(occ) == $countones(queued_o)); // R8

   AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      int'(occ) <= SLOTS); // R8

   AST_OVF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (OVF_STICKY && overflow_o) |=> overflow_o); // R8

   AST_HANDOFF_TO_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (((rel_i & grant_o) != '0) && (int'(occ) > 1)) |=> (grant_o != '0)); // R4

   AST_STRAY_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (((rel_i & grant_o) == '0) && (acq_i == '0)) |=> $stable(grant_o)); // R6

endmodule

bind aql_top aql_checker #(
   .N_REQ     (N_REQ),
   .SLOTS     (SLOTS),
   .OVF_STICKY(OVF_STICKY)
) u_aql_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .acq_i     (acq_i),
   .rel_i     (rel_i),
   .grant_o   (grant_o),
   .queued_o  (queued_o),
   .overflow_o(overflow_o),
   .holding   (holding),
   .occ       (occ)
);

// File: tb/aql_top_tb_top.sv
`timescale 1ns/1ps
module aql_top_tb_top;
   localparam int N  = 5;
   localparam int S  = 4;
   localparam int SW = $clog2(S);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  acq_i = '0;
   logic [N-1:0]  rel_i = '0;
   logic [N-1:0]  grant_o;
   logic [N-1:0]  queued_o;
   logic [N*SW-1:0] slot_o;
   logic          overflow_o;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   aql_top #(.N_REQ(N), .SLOTS(S), .OVF_STICKY(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .acq_i(acq_i), .rel_i(rel_i),
      .grant_o(grant_o), .queued_o(queued_o), .slot_o(slot_o),
      .overflow_o(overflow_o)
   );

   // behavioural reference: FIFO of requester ids
   int q[$];
   int m_slot[N];
   bit m_act[N];
   int m_next;
   bit m_ovf;

   always @(posedge clk) begin
      int occ0;
      int took;
      int h;
      bit act0[N];
      if (!rst_n) begin
         q.delete();
         m_next = 0;
         m_ovf  = 0;
         for (int i = 0; i < N; i++) begin m_act[i] = 0; m_slot[i] = 0; end
      end else begin
         occ0 = q.size();
         took = 0;
         act0 = m_act;
         for (int i = 0; i < N; i++) begin
            if (acq_i[i] && !act0[i]) begin
               if (occ0 + took < S) begin
                  m_act[i]  = 1;
                  m_slot[i] = m_next;
                  m_next    = (m_next + 1) % S;
                  q.push_back(i);
                  took++;
               end else begin
                  m_ovf = 1;
               end
            end
         end
         if (occ0 > 0 && rel_i[q[0]]) begin
            h = q.pop_front();
            m_act[h] = 0;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < N; i++) begin
            bit eg;
            eg = (q.size() > 0) && (q[0] == i);
            chk(grant_o[i] == eg, "R3 grant", int'(grant_o[i]), int'(eg));
            chk(queued_o[i] == m_act[i], "R2 queued", int'(queued_o[i]), int'(m_act[i]));
            if (m_act[i])
               chk(int'(slot_o[i*SW +: SW]) == m_slot[i], "R2 slot",
                   int'(slot_o[i*SW +: SW]), m_slot[i]);
         end
         chk(overflow_o == m_ovf, "R8 overflow", int'(overflow_o), int'(m_ovf));
      end
   end

   task automatic apply(input logic [N-1:0] a, input logic [N-1:0] r);
      @(negedge clk);
      #1;
      acq_i = a;
      rel_i = r;
      @(posedge clk);
      #1;
      acq_i = '0;
      rel_i = '0;
   endtask

   function automatic int slot_of(input int i);
      return int'(slot_o[i*SW +: SW]);
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk(grant_o == '0, "R1 grant after reset", int'(grant_o), 0);
      chk(queued_o == '0, "R1 queued after reset", int'(queued_o), 0);
      chk(overflow_o == 1'b0, "R1 overflow after reset", int'(overflow_o), 0);

      apply(5'b00001, '0);
      chk(grant_o == 5'b00001, "R1 first requester granted", int'(grant_o), 1);
      chk(slot_of(0) == 0, "R1 first place is 0", slot_of(0), 0);

      apply(5'b10110, '0);  // R2: same-edge burst in index order
      chk(slot_of(1) == 1 && slot_of(2) == 2 && slot_of(4) == 3, "R2 burst places",
          slot_of(1) * 100 + slot_of(2) * 10 + slot_of(4), 123);
      chk(queued_o == 5'b10111, "R2 burst queued", int'(queued_o), 5'b10111);

      apply(5'b01000, '0);  // R8: ring full
      chk(queued_o[3] == 1'b0, "R8 excess dropped", int'(queued_o[3]), 0);
      chk(overflow_o == 1'b1, "R8 overflow raised", int'(overflow_o), 1);

      apply('0, 5'b00010);  // R6: stray release
      chk(grant_o == 5'b00001 && queued_o == 5'b10111, "R6 stray release ignored",
          int'(grant_o), 1);

      apply(5'b00001, '0);  // R7: re-acquire while queued
      chk(slot_of(0) == 0 && queued_o == 5'b10111, "R7 re-acquire ignored", slot_of(0), 0);

      apply('0, 5'b00001);  // R4: handoff to next place
      chk(grant_o == 5'b00010, "R4 handoff 0->1", int'(grant_o), 2);
      chk(queued_o[0] == 1'b0, "R4 releaser dequeued", int'(queued_o[0]), 0);

      apply('0, 5'b00010);
      chk(grant_o == 5'b00100, "R5 FIFO second handoff", int'(grant_o), 4);
      apply('0, 5'b00100);
      chk(grant_o == 5'b10000, "R5 FIFO third handoff", int'(grant_o), 16);

      apply(5'b00001, '0);  // R9: counter wrapped to 0
      chk(slot_of(0) == 0 && queued_o[0], "R9 place reused after wrap", slot_of(0), 0);

      apply('0, 5'b10000);
      chk(grant_o == 5'b00001, "R4 handoff wraps 3->0", int'(grant_o), 1);
      apply('0, 5'b00001);
      chk(grant_o == '0 && queued_o == '0, "R10 queue empties", int'(queued_o), 0);

      apply(5'b01000, '0);  // R10: empty queue, immediate grant
      chk(grant_o == 5'b01000 && slot_of(3) == 1, "R10 immediate grant on place 1",
          int'(grant_o), 8);
      chk(overflow_o == 1'b1, "R8 overflow stays set", int'(overflow_o), 1);

      apply(5'b01000, 5'b01000);  // R7: holder re-acquires while releasing
      chk(queued_o == '0 && grant_o == '0, "R7 acquire ignored during release",
          int'(queued_o), 0);

      // random phase, compared every cycle against the model
      for (int c = 0; c < 4000; c++) begin
         logic [N-1:0] a;
         logic [N-1:0] r;
         a = '0;
         r = '0;
         for (int i = 0; i < N; i++) begin
            if ($urandom_range(99) < 20) a[i] = 1'b1;
            if ($urandom_range(99) < 10) r[i] = 1'b1;
         end
         if (q.size() > 0 && $urandom_range(99) < 45) r[q[0]] = 1'b1;
         apply(a, r);
      end

      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule